// File: doc/BRIEF.md
# Three-Phase Period-Synchronized PWM Timer

This block generates three PWM phases from a single 16-bit up-counter. The counter climbs from zero to a period value, then clears to zero and begins the next period. Each of three duty compare values produces a high-side output and a complementary low-side output. The high-side output goes high when the counter clears and goes low when the counter reaches that phase's duty value. A compare-match interrupt request line is provided for each of the eight compare slots.

The eight slots form two banks of four, named A, B, C and D. Bank 0 slot A holds the period. Bank 0 slot B, bank 1 slot A and bank 1 slot B hold the three duty values. One mode register, belonging to bank 0, controls double-buffering for both banks:
- Mode bit 0 turns slot C of each bank into the shadow of that bank's slot A.
- Mode bit 1 turns slot D of each bank into the shadow of that bank's slot B.

While a slot is shadowed, software writes go into the shadow. The written value reaches the active slot only on the clock edge at which the counter clears.

Bank 1 also has its own mode register. Its bits do not enable buffering. Instead, each of its bits switches off one of bank 1's low-side outputs. Counting is governed by a two-state run controller.

Top module: `pwm3_sync_timer`

## Requirements
- R1: After reset the counter is 0, every compare slot is 0 except slot 0 (period), which is 16'hFFFF, both mode registers are 0, `phase_hi` is 3'b000, `phase_lo` is 3'b111 and `cmp_irq` is 0.
- R2: The run controller has two states, HALT and RUN. The transition HALT→RUN is taken on any clock with `run_en` high. The transition RUN→HALT is taken on any clock with `run_en` low. The counter advances only on a clock where the state is RUN and `run_en` is high. On such a clock it increments by one, or it clears to 0 if it equals the period. Otherwise it holds.
- R3: Phase p uses duty slot 1, 4 or 5 for p = 0, 1 or 2. `phase_hi[p]` is high when the duty is nonzero and either the duty is greater than or equal to the period or the counter is below the duty. A duty of 0 keeps the output low.
- R4: `phase_lo[p]` is the inverse of `phase_hi[p]` unless that low-side output is disabled.
- R5: Bank 1 mode bit 0 forces `phase_lo[1]` to 0, and bank 1 mode bit 1 forces `phase_lo[2]` to 0. Bank 1 mode bits have no effect on buffering or on interrupts.
- R6: Writes use address 0..7 for slot 4·bank+{A=0,B=1,C=2,D=3}, address 8 for the bank 0 mode register and address 9 for the bank 1 mode register, with mode data in bits [1:0]. Addresses 10..15 are ignored. While bank 0 mode bit 0 is set, a write to an A address lands in that bank's C slot. While bank 0 mode bit 1 is set, a write to a B address lands in that bank's D slot.
- R7: On the clock where the counter clears, each buffered active slot (A if bit 0 is set, B if bit 1 is set, in both banks) loads its shadow. The new values govern the period that starts at that clear.
- R8: `cmp_irq[i]` pulses high in the cycle after a counting clock on which the counter equalled slot i.
- R9: `cmp_irq` bits 2 and 6 stay low while bank 0 mode bit 0 is set. Bits 3 and 7 stay low while bank 0 mode bit 1 is set.
- R10: With buffering off, a write lands in the addressed slot at the next clock edge and drives the outputs from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| phase_hi | output | 3 | High-side PWM outputs |
| phase_lo | output | 3 | Complementary low-side PWM outputs |
| cmp_irq | output | 8 | Compare-match interrupt requests, one per slot |

## Verification
The counter, the slots and the mode registers change at the clock edge that follows the write or count. The high-side and low-side outputs are decoded directly from those registers, so they are valid in the same cycle as the new count. An interrupt request is registered, so it appears one cycle after the counter held the matching value.

The bench keeps a reference model that it advances once per clock, using the inputs it drove for that edge. It compares every output against that model at the falling edge after the edge. This means each output is checked in exactly the cycle where it is due.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int NREG    = 8;
    localparam int ADDR_W  = 4;
    localparam int BUF_OFS = 2;
    localparam int NPH     = 3;
    localparam logic [ADDR_W-1:0] ADR_MODE0 = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_MODE1 = 4'd9;
    localparam int IDX_PER  = 0;
    localparam int IDX_DU0  = 1;
    localparam int IDX_DU1  = 4;
    localparam int IDX_DU2  = 5;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pwm3_count.sv
module pwm3_count import pwm3_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] count,
    output logic          active,
    output logic          wrap
);
    run_state_t state_q, state_d;

    // next-state logic of the run controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    assign active = (state_q == ST_RUN) && run_en;
    assign wrap   = active && (count == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (wrap)   count <= '0;
        else if (active) count <= count + 1'b1;
    end
endmodule

// File: rtl/pwm3_regs.sv
module pwm3_regs import pwm3_pkg::*; #(
    parameter int          CW         = 16,
    parameter logic [15:0] RST_PERIOD = 16'hFFFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CW-1:0]             wr_data,
    input  logic                      wrap,
    output logic [NREG-1:0][CW-1:0]   cmp,
    output logic [1:0]                mode0,
    output logic [1:0]                mode1
);
    logic [ADDR_W-1:0] tgt;

    // redirect writes of A/B slots into their shadows while buffered
    always_comb begin
        tgt = wr_addr;
        if (wr_addr < ADDR_W'(NREG)) begin
            if (!wr_addr[1] && mode0[wr_addr[0]])
                tgt = wr_addr + ADDR_W'(BUF_OFS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NREG; g++)
                cmp[g] <= (g == IDX_PER) ? CW'(RST_PERIOD) : '0;
        end else begin
            for (int g = 0; g < NREG; g++) begin
                if (wr_en && tgt == ADDR_W'(g))
                    cmp[g] <= wr_data;
                else if (wrap && (g % 4) < 2 && mode0[g % 2])
                    cmp[g] <= cmp[(g + BUF_OFS) % NREG];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode0 <= '0;
            mode1 <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_MODE0) mode0 <= wr_data[1:0];
            if (wr_addr == ADR_MODE1) mode1 <= wr_data[1:0];
        end
    end
endmodule

// File: rtl/pwm3_outs.sv
module pwm3_outs import pwm3_pkg::*; #(
    parameter int CW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           count,
    input  logic [NREG-1:0][CW-1:0] cmp,
    input  logic [1:0]              mode0,
    input  logic [1:0]              mode1,
    input  logic                    active,
    output logic [NPH-1:0]          phase_hi,
    output logic [NPH-1:0]          phase_lo,
    output logic [NREG-1:0]         cmp_irq
);
    function automatic int duty_slot(input int p);
        return (p == 0) ? IDX_DU0 : (p == 1) ? IDX_DU1 : IDX_DU2;
    endfunction

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        localparam int DI = duty_slot(p);
        logic hi;
        assign hi = (cmp[DI] != '0) &&
                    ((cmp[DI] >= cmp[IDX_PER]) || (count < cmp[DI]));
        assign phase_hi[p] = hi;
        if (p == 0) begin : g_free
            assign phase_lo[p] = ~hi;
        end else begin : g_gated
            assign phase_lo[p] = ~hi & ~mode1[p-1];
        end
    end

    logic [NREG-1:0] match;
    for (genvar g = 0; g < NREG; g++) begin : g_match
        localparam bit SHADOW = (g % 4) >= 2;
        assign match[g] = (count == cmp[g]) && !(SHADOW && mode0[g % 2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_irq <= '0;
        else if (active) cmp_irq <= match;
        else             cmp_irq <= '0;
    end
endmodule

// File: rtl/pwm3_sync_timer.sv
module pwm3_sync_timer import pwm3_pkg::*; #(
    parameter int          CW         = 16,
    parameter logic [15:0] RST_PERIOD = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     count,
    output logic [NPH-1:0]    phase_hi,
    output logic [NPH-1:0]    phase_lo,
    output logic [NREG-1:0]   cmp_irq
);
    logic [NREG-1:0][CW-1:0] cmp;
    logic [1:0]              mode0;
    logic [1:0]              mode1;
    logic                    active;
    logic                    wrap;

    pwm3_count #(.CW(CW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .period (cmp[IDX_PER]),
        .count  (count),
        .active (active),
        .wrap   (wrap)
    );

    pwm3_regs #(.CW(CW), .RST_PERIOD(RST_PERIOD)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrap    (wrap),
        .cmp     (cmp),
        .mode0   (mode0),
        .mode1   (mode1)
    );

    pwm3_outs #(.CW(CW)) u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .cmp      (cmp),
        .mode0    (mode0),
        .mode1    (mode1),
        .active   (active),
        .phase_hi (phase_hi),
        .phase_lo (phase_lo),
        .cmp_irq  (cmp_irq)
    );
endmodule

// File: rtl/pwm3_sync_timer_chk.sv
module pwm3_sync_timer_chk import pwm3_pkg::*; #(
    parameter int CW = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CW-1:0]           count,
    input logic [NREG-1:0][CW-1:0] cmp,
    input logic [1:0]              mode0,
    input logic [1:0]              mode1,
    input logic                    active,
    input logic                    wrap,
    input logic [NPH-1:0]          phase_hi,
    input logic [NPH-1:0]          phase_lo,
    input logic [NREG-1:0]         cmp_irq
);
    assert_wrap_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wrap) |=> count == $past(count) + 1'b1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(count));

    assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp[IDX_DU0] == '0) |-> !phase_hi[0]);

    assert_lo_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode1[0] |-> !phase_lo[1]);

    assert_shadow_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode0[0]) |=> cmp[IDX_PER] == $past(cmp[IDX_PER + BUF_OFS]));

    assert_period_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq[0] |-> $past(active && count == cmp[IDX_PER]));

    assert_c_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq[2] |-> !$past(mode0[0]));
endmodule

bind pwm3_sync_timer pwm3_sync_timer_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .cmp      (cmp),
    .mode0    (mode0),
    .mode1    (mode1),
    .active   (active),
    .wrap     (wrap),
    .phase_hi (phase_hi),
    .phase_lo (phase_lo),
    .cmp_irq  (cmp_irq)
);

// File: tb/pwm3_sync_timer_test.sv
module pwm3_sync_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic [2:0]  phase_hi, phase_lo;
    logic [7:0]  cmp_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model
    logic [15:0] m_reg [8];
    logic [1:0]  m_m0, m_m1;
    logic [15:0] m_cnt;
    logic        m_run;
    logic [7:0]  m_irq;

    always #4 clk = ~clk;   // 125 MHz

    pwm3_sync_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
        .phase_hi(phase_hi), .phase_lo(phase_lo), .cmp_irq(cmp_irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic exp_hi(input logic [15:0] duty, per, cnt);
        return (duty != 0) && ((duty >= per) || (cnt < duty));
    endfunction

    function automatic int duty_of(input int p);
        return (p == 0) ? 1 : (p == 1) ? 4 : 5;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = (i == 0) ? 16'hFFFF : 16'h0;
        m_m0 = 0; m_m1 = 0; m_cnt = 0; m_run = 0; m_irq = 0;
    endtask

    task automatic check_all(input string tag);
        logic [2:0] eh, el;
        for (int p = 0; p < 3; p++) begin
            eh[p] = exp_hi(m_reg[duty_of(p)], m_reg[0], m_cnt);
            el[p] = ~eh[p] & ~((p > 0) ? m_m1[p-1] : 1'b0);
        end
        chk({"R2 ", tag}, "count", 32'(count), 32'(m_cnt));
        chk({"R3 ", tag}, "phase_hi", 32'(phase_hi), 32'(eh));
        chk({"R4 R5 ", tag}, "phase_lo", 32'(phase_lo), 32'(el));
        chk({"R8 R9 ", tag}, "cmp_irq", 32'(cmp_irq), 32'(m_irq));
    endtask

    task automatic step(input logic en, input logic we, input logic [3:0] a,
                        input logic [15:0] d, input string tag);
        logic [15:0] nreg [8];
        logic        act;
        logic        wrp;
        int          t;
        @(negedge clk);
        check_all(tag);
        run_en = en; wr_en = we; wr_addr = a; wr_data = d;
        act = m_run && en;
        wrp = act && (m_cnt == m_reg[0]);
        for (int i = 0; i < 8; i++) begin
            m_irq[i] = act && (m_cnt == m_reg[i]) && !((i % 4) >= 2 && m_m0[i % 2]);
            nreg[i] = m_reg[i];
        end
        if (wrp)
            for (int i = 0; i < 8; i++)
                if ((i % 4) < 2 && m_m0[i % 2]) nreg[i] = m_reg[i + 2];
        m_cnt = wrp ? 16'h0 : act ? m_cnt + 16'h1 : m_cnt;
        if (we) begin
            if (a < 8) begin
                t = a;
                if ((a % 4) < 2 && m_m0[a % 2]) t = a + 2;
                nreg[t] = d;
            end else if (a == 8) m_m0 = d[1:0];
            else if (a == 9) m_m1 = d[1:0];
        end
        for (int i = 0; i < 8; i++) m_reg[i] = nreg[i];
        m_run = en;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'd0, 16'd0, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "count", 32'(count), 32'h0);
        chk("R1", "phase_hi", 32'(phase_hi), 32'h0);
        chk("R1", "phase_lo", 32'(phase_lo), 32'h7);
        chk("R1", "cmp_irq", 32'(cmp_irq), 32'h0);
        rst_n = 1'b1;

        // R10: direct writes with buffering off; duty 12 exceeds period 9
        step(1'b0, 1'b1, 4'd0, 16'd9, "R10");
        step(1'b0, 1'b1, 4'd1, 16'd3, "R10");
        step(1'b0, 1'b1, 4'd4, 16'd5, "R10");
        step(1'b0, 1'b1, 4'd5, 16'd12, "R10");
        run(30, "R10");
        // zero duty and duty equal to period
        step(1'b1, 1'b1, 4'd1, 16'd0, "R3");
        step(1'b1, 1'b1, 4'd4, 16'd9, "R3");
        run(12, "R3");
        // HALT and resume
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 4'd0, 16'd0, "R2");
        run(6, "R2");
        // R6 / R7: buffered writes go to shadows, load at the clear
        step(1'b1, 1'b1, 4'd8, 16'd3, "R6");
        step(1'b1, 1'b1, 4'd0, 16'd5, "R6");
        step(1'b1, 1'b1, 4'd1, 16'd2, "R6");
        step(1'b1, 1'b1, 4'd4, 16'd4, "R6");
        step(1'b1, 1'b1, 4'd5, 16'd7, "R6");
        run(25, "R7");
        // R5: low-side disable by bank 1 mode; ignored address
        step(1'b1, 1'b1, 4'd9, 16'd3, "R5");
        step(1'b1, 1'b1, 4'd12, 16'hFFFF, "R6");
        run(15, "R5");
        step(1'b1, 1'b1, 4'd9, 16'd0, "R5");
        step(1'b1, 1'b1, 4'd8, 16'd0, "R9");
        run(12, "R9");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic        en, we;
            logic [3:0]  a;
            logic [15:0] d;
            en = ($urandom % 16) != 0;
            we = ($urandom % 6) == 0;
            a  = 4'($urandom % 11);
            if (a == 0)     d = 16'(4 + $urandom % 20);
            else if (a < 8) d = 16'($urandom % 24);
            else            d = 16'($urandom % 4);
            step(en, we, a, d, "rand");
        end
        @(negedge clk);
        check_all("final");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule